// File: doc/BRIEF.md
# Daisy-Chain ADC Readback Host

This block runs the host side of a chain of serial 14-bit sampling converters that share one conversion strobe and one serial clock. Each converter's serial output feeds the serial input of the next. The host starts a conversion by raising the conversion strobe while the serial clock is high, which puts the chain into its busy-flag mode. The host keeps the strobe high through the conversion and through the readback. The output of the nearest converter does two jobs. Its rising edge tells the host that every converter has finished, and it then carries the data.

After that rising edge, the host produces a fixed burst of serial clock falling edges: fourteen for each converter, plus one more. At each falling edge it samples the serial data. The first bit it captures is the busy flag, and the host drops it. It splits the remaining bits into one word per converter, most significant bit first. Word 0 belongs to the nearest converter. The host then lowers the strobe, pulses `done_o`, and refuses new starts for a guard interval. If the flag does not rise within a set number of clocks, the host abandons the frame and pulses `err_o` instead.

Top module: `adc_chain_host`

## Requirements
- R1: Out of reset: `cnv_o` = 0, `sck_o` = 1, `ready_o` = 1, `done_o` = 0, `err_o` = 0.
- R2: A `start_i` high at a clock edge is accepted only when `ready_o` is high. `cnv_o` rises on that edge, and `sck_o` is high at that moment.
- R3: `cnv_o` stays high from acceptance until the readback ends. `sck_o` is high in every cycle where `cnv_o` is low.
- R4: No falling edge of `sck_o` occurs before `sdo_i` has risen after `cnv_o` rose.
- R5: A completed frame contains exactly 14 × N_DEV + 1 falling edges of `sck_o`.
- R6: `sdo_i` is sampled as it stands when `sck_o` falls. The first sampled bit is dropped. The next 14 × N_DEV bits fill the words MSB first, word k first and then word k+1. Word k occupies `words_o[k*14 +: 14]`, and word 0 is the nearest converter.
- R7: `done_o` pulses for one cycle in the cycle where `cnv_o` first reads low after a readback. `words_o` changes only at that point and holds until the next `done_o`.
- R8: If `sdo_i` has not risen within TIMEOUT_CYC cycles of `cnv_o` being high, `err_o` pulses for one cycle and `cnv_o` falls in that same cycle. In that frame there is no `sck_o` edge and no `done_o`, and `words_o` is unchanged.
- R9: After `cnv_o` falls, `ready_o` stays low for GAP_CYC cycles, and any `start_i` during that time is ignored.
- R10: During readback, each high and low phase of `sck_o` lasts HALF_DIV clocks, so falling edges are 2 × HALF_DIV clocks apart. The first falling edge comes HALF_DIV clocks after the flag is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a conversion and readback frame |
| sdo_i | input | 1 | Serial output of the nearest converter (flag and data) |
| cnv_o | output | 1 | Conversion strobe to all converters |
| sck_o | output | 1 | Serial clock to all converters |
| ready_o | output | 1 | High when a start will be accepted |
| done_o | output | 1 | One-cycle pulse: new words are valid |
| err_o | output | 1 | One-cycle pulse: the busy flag timed out |
| words_o | output | 14 × N_DEV | Result words, word k at bits k*14 +: 14 |

## Verification
The assertions assume that `sdo_i` is low whenever the strobe is low or the conversion is still running. They also assume that the converter chain changes `sdo_i` only after a falling edge of `sck_o`, so the value the host samples is the one that was present before the edge. The bench converter model follows these rules. It forces its output low while the strobe is low, loads the flag and the data words only after a chosen conversion latency, and shifts one cycle after each observed falling edge. Starts are issued only with `ready_o` high, except in the scenarios where rejection of `start_i` is itself the thing under test.

// File: rtl/adc_chain_pkg.sv
// Package: shared types for the daisy-chain readback host.
// Assumes nothing beyond a standard SystemVerilog flow.
package adc_chain_pkg;

    // Controller phases of one conversion/readback frame.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for start
        ST_CONV = 2'd1,   // strobe high, waiting for busy flag
        ST_READ = 2'd2,   // clocking out the chain
        ST_GAP  = 2'd3    // strobe low guard interval
    } host_state_e;

endpackage

// File: rtl/achost_sck_gen.sv
// Serial clock generator: while run is high, toggles sck every HALF_DIV
// clocks starting from high; while run is low, holds sck high.
// Strobes mark the clock in which sck is about to fall or rise.
// Assumes HALF_DIV >= 1.
module achost_sck_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic fall_stb,
    output logic rise_stb
);
    localparam int CW = $clog2(HALF_DIV + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    // Phase counter and clock toggle; idle high.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            sck <= 1'b1;
        end else if (cnt == LAST) begin
            cnt <= '0;
            sck <= ~sck;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Edge strobes for the controller and the capture register.
    always_comb begin
        fall_stb = run && sck && (cnt == LAST);
        rise_stb = run && !sck && (cnt == LAST);
    end

endmodule

// File: rtl/achost_capture.sv
// Capture register: shifts one serial bit in per enable, LSB side first in,
// so the earliest bit ends at the top. The register is one bit shorter than
// a frame, so the leading flag bit falls off the top. On latch, the words
// are copied out with word 0 (earliest after the flag) at the bottom.
// Assumes N_DEV * BITS >= 2.
module achost_capture #(
    parameter int N_DEV = 3,
    parameter int BITS  = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    shift_en,
    input  logic                    bit_in,
    input  logic                    latch,
    output logic [N_DEV*BITS-1:0]   words
);
    localparam int DATA_W = N_DEV * BITS;

    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] mapped;

    // Serial shift, earliest bit travels to the MSB end.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            shreg <= '0;
        end else if (shift_en) begin
            shreg <= {shreg[DATA_W-2:0], bit_in};
        end
    end

    // Reorder: word k sits (N_DEV-1-k) words up from the bottom of shreg.
    for (genvar k = 0; k < N_DEV; k++) begin : g_map
        assign mapped[k*BITS +: BITS] = shreg[(N_DEV-1-k)*BITS +: BITS];
    end

    // Output word register, updated only at frame completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words <= '0;
        end else if (latch) begin
            words <= mapped;
        end
    end

endmodule

// File: rtl/achost_ctrl.sv
// Frame controller: accepts a start, raises the strobe, waits for the busy
// flag edge on the serial input (with timeout), counts the readback falling
// edges, then lowers the strobe and holds off new starts for GAP_CYC cycles.
// Assumes the serial input is low while the chain is converting.
module achost_ctrl
    import adc_chain_pkg::*;
#(
    parameter int N_DEV       = 3,
    parameter int BITS        = 14,
    parameter int TIMEOUT_CYC = 200,
    parameter int GAP_CYC     = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic sdo,
    input  logic fall_stb,
    input  logic rise_stb,
    output logic sck_run,
    output logic cnv,
    output logic ready,
    output logic done,
    output logic err,
    output logic shift_en,
    output logic clear,
    output logic latch
);
    localparam int TOTAL = N_DEV * BITS + 1;
    localparam int FW    = $clog2(TOTAL + 1);
    localparam int TW    = $clog2(TIMEOUT_CYC + 1);
    localparam int GW    = $clog2(GAP_CYC + 1);
    localparam logic [FW-1:0] FALLS_END = FW'(TOTAL);
    localparam logic [TW-1:0] TO_LAST   = TW'(TIMEOUT_CYC - 1);
    localparam logic [GW-1:0] GAP_LAST  = GW'(GAP_CYC - 1);

    host_state_e   state;
    logic          sdo_q;
    logic [FW-1:0] fcnt;
    logic [TW-1:0] tcnt;
    logic [GW-1:0] gcnt;
    logic          flag_rise;
    logic          read_end;

    // Decode of flag edge, end of readback and capture controls.
    always_comb begin
        flag_rise = sdo && !sdo_q;
        read_end  = (state == ST_READ) && rise_stb && (fcnt == FALLS_END);
        shift_en  = (state == ST_READ) && fall_stb;
        clear     = (state == ST_IDLE) && start;
        latch     = read_end;
        ready     = (state == ST_IDLE);
    end

    // Delay of the serial input for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sdo_q <= 1'b0;
        else        sdo_q <= sdo;
    end

    // Frame sequencing, counters and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnv     <= 1'b0;
            sck_run <= 1'b0;
            done    <= 1'b0;
            err     <= 1'b0;
            fcnt    <= '0;
            tcnt    <= '0;
            gcnt    <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_CONV;
                        cnv   <= 1'b1;
                        tcnt  <= '0;
                    end
                end
                ST_CONV: begin
                    if (flag_rise) begin
                        state   <= ST_READ;
                        sck_run <= 1'b1;
                        fcnt    <= '0;
                    end else if (tcnt == TO_LAST) begin
                        state <= ST_GAP;
                        cnv   <= 1'b0;
                        err   <= 1'b1;
                        gcnt  <= '0;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_READ: begin
                    if (fall_stb) begin
                        fcnt <= fcnt + 1'b1;
                    end
                    if (read_end) begin
                        state   <= ST_GAP;
                        sck_run <= 1'b0;
                        cnv     <= 1'b0;
                        done    <= 1'b1;
                        gcnt    <= '0;
                    end
                end
                ST_GAP: begin
                    if (gcnt == GAP_LAST) begin
                        state <= ST_IDLE;
                    end else begin
                        gcnt <= gcnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/adc_chain_host.sv
// Top: host controller for a chain of N_DEV serial converters in busy-flag
// chain mode. Ties the clock generator, frame controller and capture
// register together. Assumes sdo_i changes only after sck_o falls.
module adc_chain_host #(
    parameter int N_DEV       = 3,
    parameter int BITS        = 14,
    parameter int HALF_DIV    = 2,
    parameter int TIMEOUT_CYC = 200,
    parameter int GAP_CYC     = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  sdo_i,
    output logic                  cnv_o,
    output logic                  sck_o,
    output logic                  ready_o,
    output logic                  done_o,
    output logic                  err_o,
    output logic [N_DEV*BITS-1:0] words_o
);
    logic sck_run;
    logic fall_stb;
    logic rise_stb;
    logic shift_en;
    logic clear;
    logic latch;

    achost_sck_gen #(.HALF_DIV(HALF_DIV)) u_sck (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (sck_run),
        .sck      (sck_o),
        .fall_stb (fall_stb),
        .rise_stb (rise_stb)
    );

    achost_ctrl #(
        .N_DEV       (N_DEV),
        .BITS        (BITS),
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .GAP_CYC     (GAP_CYC)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_i),
        .sdo      (sdo_i),
        .fall_stb (fall_stb),
        .rise_stb (rise_stb),
        .sck_run  (sck_run),
        .cnv      (cnv_o),
        .ready    (ready_o),
        .done     (done_o),
        .err      (err_o),
        .shift_en (shift_en),
        .clear    (clear),
        .latch    (latch)
    );

    achost_capture #(.N_DEV(N_DEV), .BITS(BITS)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .shift_en (shift_en),
        .bit_in   (sdo_i),
        .latch    (latch),
        .words    (words_o)
    );

endmodule

// File: rtl/achost_chk.sv
// Checker for adc_chain_host: port-level protocol properties, with small
// counters that track edge counts and phase lengths.
module achost_chk #(
    parameter int N_DEV    = 3,
    parameter int BITS     = 14,
    parameter int HALF_DIV = 2,
    parameter int GAP_CYC  = 5
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic cnv_o,
    input logic sck_o,
    input logic ready_o,
    input logic done_o,
    input logic err_o
);
    localparam int TOTAL = N_DEV * BITS + 1;
    localparam int FW    = $clog2(TOTAL + 2);
    localparam int HW    = $clog2(HALF_DIV + 2);
    localparam int LW    = $clog2(GAP_CYC + 2);

    logic          cnv_q, sck_q;
    logic [FW-1:0] falls_q;
    logic [HW-1:0] hcnt;
    logic [LW-1:0] lowcnt;

    // Edge history, falls per frame, phase length and strobe-low run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnv_q   <= 1'b0;
            sck_q   <= 1'b1;
            falls_q <= '0;
            hcnt    <= '0;
            lowcnt  <= LW'(GAP_CYC);
        end else begin
            cnv_q <= cnv_o;
            sck_q <= sck_o;
            if (cnv_o && !cnv_q)                      falls_q <= '0;
            else if (sck_q && !sck_o && falls_q != '1) falls_q <= falls_q + 1'b1;
            if (sck_o != sck_q)   hcnt <= HW'(1);
            else if (hcnt != '1)  hcnt <= hcnt + 1'b1;
            if (cnv_o)              lowcnt <= '0;
            else if (lowcnt != '1)  lowcnt <= lowcnt + 1'b1;
        end
    end

    // R2
    cnv_rise_sck_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_o) |-> sck_o);
    // R2
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_o) |-> $past(start_i && ready_o));
    // R3
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnv_o |-> sck_o);
    // R5
    fall_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (falls_q == FW'(TOTAL)));
    // R7
    done_cnv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!cnv_o && cnv_q));
    // R8
    timeout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (falls_q == '0 && !cnv_o && !done_o));
    // R9
    gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_o && !cnv_q) |-> (lowcnt >= LW'(GAP_CYC)));
    // R10
    low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_o && !sck_q) |-> (hcnt == HW'(HALF_DIV)));

endmodule

bind adc_chain_host achost_chk #(
    .N_DEV    (N_DEV),
    .BITS     (BITS),
    .HALF_DIV (HALF_DIV),
    .GAP_CYC  (GAP_CYC)
) u_chk (.*);

// File: tb/test_adc_chain_host.sv
// Directed bench: a behavioural converter chain drives sdo_i; each task runs
// one scenario and checks its own results.
module test_adc_chain_host;
    localparam int CLK_PERIOD  = 10;
    localparam int N_DEV       = 3;
    localparam int BITS        = 14;
    localparam int HALF_DIV    = 2;
    localparam int TIMEOUT_CYC = 200;
    localparam int GAP_CYC     = 5;
    localparam int TOTAL       = N_DEV * BITS + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic sdo_i;
    logic cnv_o, sck_o, ready_o, done_o, err_o;
    logic [N_DEV*BITS-1:0] words_o;

    int checks = 0;
    int errors = 0;

    // Converter chain model state.
    logic [BITS-1:0]  mw [N_DEV];
    int               mlat = 10;
    logic             hang = 1'b0;
    logic [TOTAL-1:0] chain_sr = '0;
    logic             m_sck_q = 1'b1, m_cnv_q = 1'b0;
    logic             busy = 1'b0, loaded = 1'b0, sck_at_rise = 1'b1;
    int               lat_cnt = 0;
    int               falls = 0, low_falls = 0, early_falls = 0;
    int               cyc = 0, last_fall = -1, iv_min = 1000, iv_max = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sdo_i = chain_sr[TOTAL-1];

    adc_chain_host #(
        .N_DEV(N_DEV), .BITS(BITS), .HALF_DIV(HALF_DIV),
        .TIMEOUT_CYC(TIMEOUT_CYC), .GAP_CYC(GAP_CYC)
    ) i_adc_chain_host (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sdo_i(sdo_i),
        .cnv_o(cnv_o), .sck_o(sck_o), .ready_o(ready_o), .done_o(done_o),
        .err_o(err_o), .words_o(words_o)
    );

    // Chain model: low output while strobe low, loads flag+words after
    // latency, shifts one cycle after each observed sck fall.
    always @(posedge clk) begin
        logic [TOTAL-1:0] img;
        logic fall;
        cyc++;
        fall = m_sck_q && !sck_o;
        if (cnv_o && !m_cnv_q) begin
            busy = 1'b1; lat_cnt = 0; loaded = 1'b0;
            sck_at_rise = sck_o; last_fall = -1; iv_min = 1000; iv_max = 0;
        end
        if (fall) begin
            falls++;
            if (!cnv_o) low_falls++;
            if (cnv_o && !loaded) early_falls++;
            if (last_fall >= 0) begin
                if (cyc - last_fall < iv_min) iv_min = cyc - last_fall;
                if (cyc - last_fall > iv_max) iv_max = cyc - last_fall;
            end
            last_fall = cyc;
        end
        if (!cnv_o) begin
            chain_sr <= '0;
        end else if (busy && lat_cnt == mlat && !hang) begin
            img = '0;
            img[TOTAL-1] = 1'b1;
            for (int k = 0; k < N_DEV; k++) img[TOTAL-2-k*BITS -: BITS] = mw[k];
            chain_sr <= img;
            busy = 1'b0; loaded = 1'b1;
        end else if (fall) begin
            chain_sr <= chain_sr << 1;
        end
        if (busy) lat_cnt++;
        m_sck_q <= sck_o;
        m_cnv_q <= cnv_o;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        check(cnv_o == 1'b0, "R1 cnv", int'(cnv_o), 0);
        check(sck_o == 1'b1, "R1 sck", int'(sck_o), 1);
        check(ready_o == 1'b1, "R1 ready", int'(ready_o), 1);
        check(done_o == 1'b0 && err_o == 1'b0, "R1 done/err", int'({done_o, err_o}), 0);
    endtask

    // One full frame; poke issues a stray start mid-frame, gap_poke drives
    // start during the guard interval.
    task automatic t_frame(input logic [BITS-1:0] a, input logic [BITS-1:0] b,
                           input logic [BITS-1:0] c, input int lat,
                           input logic poke, input logic gap_poke);
        int f0, lf0, n;
        logic got_done, got_err;
        mw[0] = a; mw[1] = b; mw[2] = c; mlat = lat; hang = 1'b0;
        f0 = falls; lf0 = low_falls;
        check(ready_o == 1'b1, "R2 ready before start", int'(ready_o), 1);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        check(cnv_o == 1'b1, "R2 cnv raised", int'(cnv_o), 1);
        got_done = 1'b0; got_err = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            if (poke && i == 20) start_i = 1'b1;
            if (poke && i == 21) start_i = 1'b0;
            if (done_o) begin got_done = 1'b1; break; end
            if (err_o) got_err = 1'b1;
            if (!cnv_o) break;
            @(negedge clk);
        end
        check(got_done && !got_err, "R7 done seen", int'(got_done), 1);
        check(cnv_o == 1'b0, "R7 cnv low with done", int'(cnv_o), 0);
        check(sck_at_rise == 1'b1, "R2 sck at cnv rise", int'(sck_at_rise), 1);
        check(falls - f0 == TOTAL, "R5 fall count", falls - f0, TOTAL);
        check(low_falls == lf0, "R3 no falls with cnv low", low_falls - lf0, 0);
        check(early_falls == 0, "R4 no early falls", early_falls, 0);
        check(iv_min == 2*HALF_DIV && iv_max == 2*HALF_DIV, "R10 fall spacing",
              iv_max, 2*HALF_DIV);
        for (int k = 0; k < N_DEV; k++)
            check(words_o[k*BITS +: BITS] == mw[k], "R6 word",
                  int'(words_o[k*BITS +: BITS]), int'(mw[k]));
        n = 0;
        while (!ready_o && n < 100) begin
            n++;
            if (gap_poke && n == 1) start_i = 1'b1;
            if (gap_poke && n == GAP_CYC-1) start_i = 1'b0;
            @(negedge clk);
        end
        check(n == GAP_CYC, "R9 guard length", n, GAP_CYC);
        for (int i = 0; i < 3; i++) begin
            check(cnv_o == 1'b0, "R9 start ignored in guard", int'(cnv_o), 0);
            @(negedge clk);
        end
        for (int k = 0; k < N_DEV; k++)
            check(words_o[k*BITS +: BITS] == mw[k], "R7 words held",
                  int'(words_o[k*BITS +: BITS]), int'(mw[k]));
    endtask

    task automatic t_timeout();
        int f0, hi;
        logic [N_DEV*BITS-1:0] prev;
        logic got_err, got_done;
        prev = words_o; hang = 1'b1; f0 = falls;
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        hi = 0; got_err = 1'b0; got_done = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            if (done_o) got_done = 1'b1;
            if (err_o) begin got_err = 1'b1; break; end
            if (cnv_o) hi++;
            @(negedge clk);
        end
        check(got_err, "R8 err pulse", int'(got_err), 1);
        check(!got_done && !done_o, "R8 no done", int'(done_o), 0);
        check(cnv_o == 1'b0, "R8 cnv low at err", int'(cnv_o), 0);
        check(hi == TIMEOUT_CYC, "R8 timeout length", hi, TIMEOUT_CYC);
        check(falls == f0, "R8 no sck edges", falls - f0, 0);
        check(words_o == prev, "R8 words unchanged", int'(words_o[BITS-1:0]), int'(prev[BITS-1:0]));
        @(negedge clk);
        check(err_o == 1'b0, "R8 err single cycle", int'(err_o), 0);
        while (!ready_o) @(negedge clk);
        hang = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_frame(14'h3FFF, 14'h0000, 14'h2AAA, 10, 1'b0, 1'b0);
        t_frame(14'h0001, 14'h2000, 14'h1555, 30, 1'b1, 1'b0);
        t_timeout();
        t_frame(14'h1234, 14'h0ABC, 14'h3C0F, 3, 1'b0, 1'b1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule